// File: doc/BRIEF.md
# Predicated Instruction Bundle Dispatcher

The dispatcher sits at the front of a wide in-order issue stage. Each cycle it may take in two 128-bit instruction bundles, a first one (A) and a second one (B). Every bundle holds a 5-bit template and three 41-bit instruction slots. The block splits each bundle into its slots and pulls out each slot's major opcode and qualifying-predicate index. It then emits six slot records in program order, one cycle later.

Each record carries an issue flag. The flag is set when the instruction's qualifying predicate reads true. It is clear when that predicate reads false, which means the instruction is nullified and its result must be thrown away. The predicates live in a 64-entry one-bit register file inside the block, and an external result port writes it. Entry 0 is the always-true predicate.

Top module: `bundle_dispatch_top`

## Requirements
- R1: While reset is asserted, outValid is all zero and inReady is low. Reset sets predicates 1 to 63 to 0 and predicate 0 to 1.
- R2: inReady rises on the first clock edge after reset is released and stays high from then on. A bundle is taken on an edge where its valid input and inReady are both high.
- R3: In a bundle, bits 4:0 are the template. Slot k (k = 0, 1, 2) occupies bits 5+41k+40 down to 5+41k. In each slot, bits 40:37 are the major opcode and bits 5:0 are the qualifying-predicate index. Lane L's opcode appears on outOpcode[4L+3:4L], its predicate index on outQp[6L+5:6L] and its whole slot on outSlot[41L+40:41L].
- R4: Output lanes 0, 1 and 2 carry slots 0, 1 and 2 of bundle A. Lanes 3, 4 and 5 carry slots 0, 1 and 2 of bundle B. outTemplate[4:0] is A's template and outTemplate[9:5] is B's.
- R5: A record appears on the edge that takes its bundle and lasts one cycle. The three lanes of a bundle that was not taken show outValid low in the following cycle.
- R6: A valid lane has outIssue equal to the predicate that its qualifying index names, as that predicate stood before the edge. A value of 0 means nullify.
- R7: Predicate 0 always reads 1. A write that targets index 0 has no effect.
- R8: A predicate write (predWrEn, predWrIdx, predWrData) updates the file on the clock edge. A read on that same edge still sees the old value, and the next edge sees the new one.
- R9: outIssue is 0 on every lane whose outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValidA | input | 1 | Bundle A present |
| inBundleA | input | 128 | First bundle in program order |
| inValidB | input | 1 | Bundle B present |
| inBundleB | input | 128 | Second bundle in program order |
| inReady | output | 1 | Block accepts bundles |
| predWrEn | input | 1 | Predicate write strobe |
| predWrIdx | input | 6 | Predicate index to write |
| predWrData | input | 1 | Predicate value to write |
| outValid | output | 6 | Per-lane record valid |
| outIssue | output | 6 | Per-lane issue (1) or nullify (0) |
| outOpcode | output | 24 | Per-lane major opcode, 4 bits each |
| outQp | output | 36 | Per-lane qualifying-predicate index, 6 bits each |
| outSlot | output | 246 | Per-lane full 41-bit slot |
| outTemplate | output | 10 | Template of A (low) and B (high) |

## Verification
The bench instantiates the block with its default widths: 41-bit slots, a 5-bit template, a 4-bit opcode and a 6-bit predicate index, which makes 64 predicates and six lanes. With those widths, index 63 and the wrap from 63 back to 0 can both be reached. Bundle A and bundle B can each be valid or idle in any combination, in the same cycle. A write to a predicate can land in the same cycle as a read of that predicate. A write aimed at the always-true entry can also be issued and its lack of effect observed.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int NUM_BUNDLES = 2;

  typedef struct packed {
    logic [NUM_BUNDLES-1:0] take;
    logic                   predWe;
  } dispCtrl_t;
endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
#(
  parameter int QP_W = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_BUNDLES-1:0] inValid,
  input  logic                   predWrEn,
  input  logic [QP_W-1:0]        predWrIdx,
  output logic                   inReady,
  output dispCtrl_t              ctrl
);
  logic readyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign inReady = readyQ;

  always_comb begin
    ctrl.take   = inValid & {NUM_BUNDLES{readyQ}};
    // the always-true entry is never written
    ctrl.predWe = predWrEn && (predWrIdx != '0);
  end

  a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> inReady);
endmodule

// File: rtl/dispatch_dp.sv
module dispatch_dp
  import dispatch_pkg::*;
#(
  parameter int TMPL_W = 5,
  parameter int SLOT_W = 41,
  parameter int SLOTS  = 3,
  parameter int OPC_W  = 4,
  parameter int QP_W   = 6,
  localparam int BUNDLE_W = TMPL_W + SLOTS * SLOT_W,
  localparam int LANES    = NUM_BUNDLES * SLOTS,
  localparam int NPRED    = 1 << QP_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dispCtrl_t                     ctrl,
  input  logic [NUM_BUNDLES*BUNDLE_W-1:0] inBundle,
  input  logic [QP_W-1:0]               predWrIdx,
  input  logic                          predWrData,
  output logic [LANES-1:0]              outValid,
  output logic [LANES-1:0]              outIssue,
  output logic [LANES*OPC_W-1:0]        outOpcode,
  output logic [LANES*QP_W-1:0]         outQp,
  output logic [LANES*SLOT_W-1:0]       outSlot,
  output logic [NUM_BUNDLES*TMPL_W-1:0] outTemplate
);
  logic [NPRED-1:0] predQ;

  // predicate file: entry 0 resets to 1 and is never written
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            predQ <= NPRED'(1);
    else if (ctrl.predWe) predQ[predWrIdx] <= predWrData;
  end

  for (genvar b = 0; b < NUM_BUNDLES; b++) begin : g_bnd
    logic [TMPL_W-1:0] tmplQ;

    always_ff @(posedge clk) begin
      if (ctrl.take[b]) tmplQ <= inBundle[b*BUNDLE_W +: TMPL_W];
    end

    assign outTemplate[b*TMPL_W +: TMPL_W] = tmplQ;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int LANE = b * SLOTS + s;
      logic [SLOT_W-1:0] slotIn;
      logic [SLOT_W-1:0] slotQ;
      logic              validQ;
      logic              issueQ;

      assign slotIn = inBundle[b*BUNDLE_W + TMPL_W + s*SLOT_W +: SLOT_W];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ <= 1'b0;
          issueQ <= 1'b0;
        end else begin
          validQ <= ctrl.take[b];
          issueQ <= ctrl.take[b] & predQ[slotIn[QP_W-1:0]];
        end
      end

      always_ff @(posedge clk) begin
        if (ctrl.take[b]) slotQ <= slotIn;
      end

      assign outValid[LANE]                  = validQ;
      assign outIssue[LANE]                  = issueQ;
      assign outSlot[LANE*SLOT_W +: SLOT_W]  = slotQ;
      assign outOpcode[LANE*OPC_W +: OPC_W]  = slotQ[SLOT_W-1 -: OPC_W];
      assign outQp[LANE*QP_W +: QP_W]        = slotQ[QP_W-1:0];

      a_r5_lane_follows_take: assert property (@(posedge clk) disable iff (!rstN)
        ctrl.take[b] |=> validQ);
      a_r5_idle_lane_quiet: assert property (@(posedge clk) disable iff (!rstN)
        !ctrl.take[b] |=> !validQ);
      a_r9_issue_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
        issueQ |-> validQ);
      a_r7_pred0_issues: assert property (@(posedge clk) disable iff (!rstN)
        (validQ && slotQ[QP_W-1:0] == '0) |-> issueQ);
    end
  end
endmodule

// File: rtl/bundle_dispatch_top.sv
module bundle_dispatch_top
  import dispatch_pkg::*;
#(
  parameter int TMPL_W = 5,
  parameter int SLOT_W = 41,
  parameter int SLOTS  = 3,
  parameter int OPC_W  = 4,
  parameter int QP_W   = 6,
  localparam int BUNDLE_W = TMPL_W + SLOTS * SLOT_W,
  localparam int LANES    = NUM_BUNDLES * SLOTS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValidA,
  input  logic [BUNDLE_W-1:0]           inBundleA,
  input  logic                          inValidB,
  input  logic [BUNDLE_W-1:0]           inBundleB,
  output logic                          inReady,
  input  logic                          predWrEn,
  input  logic [QP_W-1:0]               predWrIdx,
  input  logic                          predWrData,
  output logic [LANES-1:0]              outValid,
  output logic [LANES-1:0]              outIssue,
  output logic [LANES*OPC_W-1:0]        outOpcode,
  output logic [LANES*QP_W-1:0]         outQp,
  output logic [LANES*SLOT_W-1:0]       outSlot,
  output logic [NUM_BUNDLES*TMPL_W-1:0] outTemplate
);
  dispCtrl_t ctrl;

  dispatch_ctrl #(.QP_W(QP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   ({inValidB, inValidA}),
    .predWrEn  (predWrEn),
    .predWrIdx (predWrIdx),
    .inReady   (inReady),
    .ctrl      (ctrl)
  );

  dispatch_dp #(
    .TMPL_W (TMPL_W),
    .SLOT_W (SLOT_W),
    .SLOTS  (SLOTS),
    .OPC_W  (OPC_W),
    .QP_W   (QP_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .inBundle    ({inBundleB, inBundleA}),
    .predWrIdx   (predWrIdx),
    .predWrData  (predWrData),
    .outValid    (outValid),
    .outIssue    (outIssue),
    .outOpcode   (outOpcode),
    .outQp       (outQp),
    .outSlot     (outSlot),
    .outTemplate (outTemplate)
  );
endmodule

// File: tb/bundle_dispatch_top_bench.sv
module bundle_dispatch_top_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValidA = 1'b0, inValidB = 1'b0;
  logic [127:0] inBundleA = '0, inBundleB = '0;
  logic         inReady;
  logic         predWrEn = 1'b0;
  logic [5:0]   predWrIdx = '0;
  logic         predWrData = 1'b0;
  logic [5:0]   outValid, outIssue;
  logic [23:0]  outOpcode;
  logic [35:0]  outQp;
  logic [245:0] outSlot;
  logic [9:0]   outTemplate;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;  // 4 ns period

  bundle_dispatch_top u_bundle_dispatch_top (
    .clk(clk), .rstN(rstN),
    .inValidA(inValidA), .inBundleA(inBundleA),
    .inValidB(inValidB), .inBundleB(inBundleB),
    .inReady(inReady),
    .predWrEn(predWrEn), .predWrIdx(predWrIdx), .predWrData(predWrData),
    .outValid(outValid), .outIssue(outIssue), .outOpcode(outOpcode),
    .outQp(outQp), .outSlot(outSlot), .outTemplate(outTemplate)
  );

  typedef struct packed {
    logic        vA;
    logic        vB;
    logic        wrEn;
    logic [5:0]  wrIdx;
    logic        wrData;
    logic [5:0]  qpBase;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b1, 1'b1, 6'd3,  1'b1, 6'd0,  16'h1234}, // R8: p3 written now, read old 0
    '{1'b1, 1'b1, 1'b1, 6'd5,  1'b1, 6'd0,  16'h5678}, // R8: p3 now visible
    '{1'b1, 1'b0, 1'b1, 6'd0,  1'b0, 6'd0,  16'h9abc}, // R7: write to p0 dropped
    '{1'b1, 1'b1, 1'b0, 6'd0,  1'b0, 6'd0,  16'hdef0}, // R7: p0 still true
    '{1'b0, 1'b1, 1'b1, 6'd63, 1'b1, 6'd60, 16'h0f0f}, // R4: only B
    '{1'b1, 1'b1, 1'b0, 6'd0,  1'b0, 6'd60, 16'hf00d}, // R6: p63 and wrap to p0
    '{1'b0, 1'b0, 1'b1, 6'd3,  1'b0, 6'd0,  16'h4321}, // R5: nothing taken
    '{1'b1, 1'b1, 1'b0, 6'd0,  1'b0, 6'd1,  16'hbeef}  // R6: p3 cleared, p5 set
  };

  logic [63:0]  predM;
  logic [5:0]   expValid, expIssue;
  logic [23:0]  expOpc;
  logic [35:0]  expQp;
  logic [245:0] expSlot;
  logic [9:0]   expTmpl;

  function automatic logic [40:0] slotOf(input logic [15:0] seed, input int lane,
                                          input logic [5:0] qp);
    logic [3:0] opc;
    opc = seed[3:0] + 4'(lane);
    return {opc, seed, 4'(lane), 11'h5a5, qp};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one vector and build its expectation from the bench's own predicate model
  task automatic applyVec(input vec_t v);
    logic [127:0] bnd [2];
    logic         vld [2];
    vld[0] = v.vA;
    vld[1] = v.vB;
    expValid = '0; expIssue = '0; expOpc = '0; expQp = '0; expSlot = '0;
    for (int b = 0; b < 2; b++) begin
      logic [4:0] tm;
      tm = v.seed[4:0] ^ 5'(b * 9);
      bnd[b] = {123'(0), tm};
      if (vld[b]) expTmpl[b*5 +: 5] = tm;
      for (int s = 0; s < 3; s++) begin
        int l;
        logic [5:0] qp;
        logic [40:0] sl;
        l  = b * 3 + s;
        qp = v.qpBase + 6'(l);
        sl = slotOf(v.seed, l, qp);
        bnd[b][5 + s*41 +: 41] = sl;
        if (vld[b]) begin
          expValid[l]       = 1'b1;
          expIssue[l]       = predM[qp];
          expSlot[l*41 +: 41] = sl;
          expOpc[l*4 +: 4]  = v.seed[3:0] + 4'(l);
          expQp[l*6 +: 6]   = qp;
        end
      end
    end
    inValidA = v.vA; inBundleA = bnd[0];
    inValidB = v.vB; inBundleB = bnd[1];
    predWrEn = v.wrEn; predWrIdx = v.wrIdx; predWrData = v.wrData;
    if (v.wrEn && v.wrIdx != 6'd0) predM[v.wrIdx] = v.wrData;
  endtask

  task automatic checkOut(input string tag);
    logic [245:0] actSlot;
    logic [23:0]  actOpc;
    logic [35:0]  actQp;
    logic [9:0]   actT, eT;
    actSlot = '0; actOpc = '0; actQp = '0; actT = '0; eT = '0;
    for (int l = 0; l < 6; l++) begin
      if (outValid[l]) begin
        actSlot[l*41 +: 41] = outSlot[l*41 +: 41];
        actOpc[l*4 +: 4]    = outOpcode[l*4 +: 4];
        actQp[l*6 +: 6]     = outQp[l*6 +: 6];
      end
    end
    for (int b = 0; b < 2; b++) begin
      if (expValid[b*3]) begin
        actT[b*5 +: 5] = outTemplate[b*5 +: 5];
        eT[b*5 +: 5]   = expTmpl[b*5 +: 5];
      end
    end
    chk(outValid == expValid, {"R5 valid ", tag}, 256'(outValid), 256'(expValid));
    chk(outIssue == expIssue, {"R6 R9 issue ", tag}, 256'(outIssue), 256'(expIssue));
    chk(actSlot == expSlot, {"R4 slot ", tag}, 256'(actSlot), 256'(expSlot));
    chk({actOpc, actQp} == {expOpc, expQp}, {"R3 opcode/qp ", tag},
        256'({actOpc, actQp}), 256'({expOpc, expQp}));
    chk(actT == eT, {"R3 R4 template ", tag}, 256'(actT), 256'(eT));
  endtask

  task automatic idleInputs();
    inValidA = 1'b0; inValidB = 1'b0; predWrEn = 1'b0;
  endtask

  initial begin
    predM = 64'd1;
    repeat (3) @(negedge clk);
    chk(outValid == 6'd0, "R1 outValid in reset", 256'(outValid), 256'd0);
    chk(inReady == 1'b0, "R1 inReady in reset", 256'(inReady), 256'd0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(inReady == 1'b1, "R2 inReady after reset", 256'(inReady), 256'd1);

    for (int i = 0; i < 8; i++) begin
      applyVec(VEC[i]);
      @(posedge clk); @(negedge clk);
      checkOut($sformatf("vec%0d", i));
    end

    // R5: one-cycle record, then quiet when idle
    applyVec(VEC[3]);
    @(posedge clk); @(negedge clk);
    checkOut("single");
    idleInputs();
    @(posedge clk); @(negedge clk);
    chk(outValid == 6'd0, "R5 record lasts one cycle", 256'(outValid), 256'd0);
    chk(outIssue == 6'd0, "R9 issue low when idle", 256'(outIssue), 256'd0);

    // R1: a second reset clears predicates (p63 was set earlier)
    rstN = 1'b0;
    @(negedge clk);
    chk(outValid == 6'd0, "R1 outValid in second reset", 256'(outValid), 256'd0);
    rstN = 1'b1;
    predM = 64'd1;
    @(posedge clk); @(negedge clk);
    applyVec(VEC[5]);
    @(posedge clk); @(negedge clk);
    checkOut("R1 after reset");
    idleInputs();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule